// File: doc/BRIEF.md
# Hypercube Circuit Path Builder

This block finds and reserves a circuit-switched route between two nodes of a binary hypercube with 2^DIMS nodes. Node addresses are DIMS-bit numbers, and every node links to the DIMS neighbours whose addresses differ from its own in exactly one bit. Links that other routes already hold are supplied as a busy map. Some nodes carry a fence bit. A route may start or end at a fenced node but may never pass through one.

After a start strobe, the block runs a depth-first search with one step per clock. Each node keeps its own register of remaining candidate links. A candidate link moves one bit closer to the destination, is free, and does not lead into a fenced node that is not the destination. The active node takes its lowest candidate and reserves that link. A node with no candidate left backs off to its predecessor and frees the link between them. The predecessor then drops the candidate that failed and tries its next-higher one.

The search ends in one of two ways. It reaches the destination, and the hop list and the updated busy map are presented. Or the source runs out of candidates, and failure is reported with the busy map restored. Because each hop moves one bit closer, the active node's address parity alternates on every step. Moving data over the route and tearing it down belong to other blocks.

Top module: `hc_path_engine`

## Requirements
- R1: After reset, done_o, ok_o and hop_cnt_o are 0 and busy_o is all zero.
- R2: When src_i equals dst_i, done_o rises 2 cycles after the edge that samples start_i, with ok_o=1, hop_cnt_o=0, and busy_o equal to busy_init_i.
- R3: With no busy links and no fenced nodes, the route takes one hop per bit in which src_i and dst_i differ, in ascending bit order. hops_o[i*DW +: DW] holds the dimension of hop i, with hop 0 leaving the source. hop_cnt_o equals the Hamming distance h, and done_o rises h+2 cycles after the sampling edge.
- R4: The link between node a and node a^(1<<d) counts as busy when busy_init_i bit a*DIMS+d or bit (a^(1<<d))*DIMS+d is set. A busy link is never taken.
- R5: On success, busy_o equals busy_init_i with both end bits (node*DIMS+d) set for every link on the route. No other bit changes.
- R6: A fenced node (iso_i[node]=1) is never an intermediate node of a route. It may still be the source or the destination.
- R7: On a dead end, the search backs off and tries the next-higher candidate at the predecessor. The route reported is the first one found by depth-first search that tries dimensions lowest first.
- R8: When no route exists, done_o rises with ok_o=0 and hop_cnt_o=0, and busy_o equals busy_init_i.
- R9: A route never holds more than DIMS hops, and every hop reduces the distance to the destination by one.
- R10: A start_i pulse that arrives while a search is running is ignored and does not change that search's result.
- R11: done_o is a single-cycle pulse. ok_o, hop_cnt_o, hops_o and busy_o hold their values until the next accepted start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search; accepted only while idle |
| src_i | input | DIMS | Source node address |
| dst_i | input | DIMS | Destination node address |
| busy_init_i | input | NODES*DIMS | Busy map of held links; bit node*DIMS+d marks that node's link in dimension d |
| iso_i | input | NODES | Fence bit for each node |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | 1 when a route was built, 0 on failure |
| hop_cnt_o | output | CW | Number of hops in the route |
| hops_o | output | DIMS*DW | Dimension of each hop, hop 0 in the low field |
| busy_o | output | NODES*DIMS | Updated busy map |

## Verification
The bench sweeps every source and destination pair on a clean cube. This catches a wrong selection order, a wrong hop count or an off-by-one completion time. It then checks many pseudo-random busy and fence patterns against an arithmetic depth-first model. A design that forgot to clear the failed candidate bit would loop until the watchdog fires. A design that freed only one end of a backed-off link would leave stray bits in the returned map. Directed cases cover the remaining corners. A fenced middle node must force a detour, while a fenced destination must still be reached. A fully blocked source must fail with the map untouched. A start pulse in the middle of a search must not disturb that search.

// File: rtl/hc_pkg.sv
package hc_pkg;

    localparam int HC_DIMS = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRIME,
        ST_SEARCH
    } eng_state_e;

    // one-hot decision of the active node in a search cycle
    typedef struct packed {
        logic hop;
        logic back;
        logic win;
        logic lose;
    } step_t;

    // index of the lowest set bit, 0 when the vector is empty
    function automatic int lowest_set(input logic [31:0] v);
        int r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

    function automatic int dim_width(input int dims);
        return (dims > 1) ? $clog2(dims) : 1;
    endfunction

endpackage

// File: rtl/hc_node.sv
module hc_node #(
    parameter int DIMS = 4,
    parameter int ID   = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DIMS-1:0] dst_i,
    input  logic [DIMS-1:0] busy_i,
    input  logic [DIMS-1:0] pass_i,
    input  logic            enter_i,
    input  logic            nogo_i,
    output logic [DIMS-1:0] cand_o
);
    typedef logic [DIMS-1:0] addr_t;
    localparam addr_t HERE = addr_t'(ID);

    addr_t cand_q;
    addr_t cand_d;

    always_comb begin
        cand_d = (HERE ^ dst_i) & ~busy_i & pass_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q <= '0;
        end else if (enter_i) begin
            cand_q <= cand_d;
        end else if (nogo_i) begin
            cand_q <= cand_q & (cand_q - addr_t'(1));
        end
    end

    assign cand_o = cand_q;

    // R7
    nogo_target_chk: assert property (@(posedge clk) disable iff (rst)
        nogo_i |-> (cand_q != '0));

endmodule

// File: rtl/hc_link_map.sv
module hc_link_map #(
    parameter int DIMS  = 4,
    parameter int NODES = 16,
    parameter int DW    = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_i,
    input  logic [NODES*DIMS-1:0] init_i,
    input  logic                  claim_i,
    input  logic                  release_i,
    input  logic [DIMS-1:0]       node_i,
    input  logic [DW-1:0]         dim_i,
    output logic [NODES*DIMS-1:0] map_o
);
    typedef logic [DIMS-1:0] addr_t;

    logic [NODES*DIMS-1:0] map_q;
    logic [NODES*DIMS-1:0] map_d;
    addr_t                 far_end;

    always_comb begin
        far_end = node_i ^ (addr_t'(1) << dim_i);
        map_d   = map_q;
        for (int n = 0; n < NODES; n++) begin
            for (int d = 0; d < DIMS; d++) begin
                if ((claim_i || release_i) && (int'(dim_i) == d) &&
                    ((node_i == addr_t'(n)) || (far_end == addr_t'(n)))) begin
                    map_d[n*DIMS+d] = claim_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= '0;
        end else if (load_i) begin
            map_q <= init_i;
        end else begin
            map_q <= map_d;
        end
    end

    assign map_o = map_q;

    // R4
    claim_release_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(claim_i && release_i));

endmodule

// File: rtl/hc_hop_stack.sv
module hc_hop_stack #(
    parameter int DIMS = 4,
    parameter int DW   = 2,
    parameter int CW   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear_i,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic [DW-1:0]      dim_i,
    output logic [CW-1:0]      depth_o,
    output logic [DW-1:0]      top_o,
    output logic [DIMS*DW-1:0] flat_o
);
    logic [DW-1:0] ent_q [DIMS];
    logic [CW-1:0] depth_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
            for (int i = 0; i < DIMS; i++) ent_q[i] <= '0;
        end else if (clear_i) begin
            depth_q <= '0;
        end else if (push_i) begin
            for (int i = 0; i < DIMS; i++) begin
                if (depth_q == CW'(i)) ent_q[i] <= dim_i;
            end
            depth_q <= depth_q + CW'(1);
        end else if (pop_i) begin
            depth_q <= depth_q - CW'(1);
        end
    end

    always_comb begin
        top_o = '0;
        for (int i = 0; i < DIMS; i++) begin
            if (depth_q == CW'(i + 1)) top_o = ent_q[i];
        end
    end

    for (genvar g = 0; g < DIMS; g++) begin : g_flat
        assign flat_o[g*DW +: DW] = ent_q[g];
    end

    assign depth_o = depth_q;

    // R9
    stack_room_chk: assert property (@(posedge clk) disable iff (rst)
        push_i |-> (depth_q < CW'(DIMS)));

    // R7
    stack_pop_chk: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> (depth_q != '0));

endmodule

// File: rtl/hc_path_engine.sv
module hc_path_engine
    import hc_pkg::*;
#(
    parameter int DIMS = HC_DIMS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic [DIMS-1:0]               src_i,
    input  logic [DIMS-1:0]               dst_i,
    input  logic [(1<<DIMS)*DIMS-1:0]     busy_init_i,
    input  logic [(1<<DIMS)-1:0]          iso_i,
    output logic                          done_o,
    output logic                          ok_o,
    output logic [$clog2(DIMS+1)-1:0]     hop_cnt_o,
    output logic [DIMS*dim_width(DIMS)-1:0] hops_o,
    output logic [(1<<DIMS)*DIMS-1:0]     busy_o
);
    localparam int NODES = 1 << DIMS;
    localparam int DW    = dim_width(DIMS);
    localparam int CW    = $clog2(DIMS + 1);

    typedef logic [DIMS-1:0] addr_t;
    typedef logic [DW-1:0]   dim_t;

    eng_state_e state_q;
    addr_t      cur_q, src_q, dst_q;
    logic [NODES-1:0] iso_q;
    logic       done_q, ok_q;

    logic [NODES*DIMS-1:0] map;
    logic [DIMS-1:0] cand_all [NODES];
    logic [DIMS-1:0] eff_all  [NODES];
    logic [NODES-1:0] enter_vec, nogo_vec;

    logic [CW-1:0] depth;
    dim_t          back_dim;
    step_t         step;
    addr_t         cur_cand, nbr, prev;
    dim_t          hop_dim, link_dim;
    logic          claim, rel, load;

    // per-node link state and candidate registers
    for (genvar g = 0; g < NODES; g++) begin : g_node
        logic [DIMS-1:0] eff, pass;
        for (genvar d = 0; d < DIMS; d++) begin : g_dim
            localparam int NB = g ^ (1 << d);
            assign eff[d]  = map[g*DIMS+d] | map[NB*DIMS+d];
            assign pass[d] = !iso_q[NB] || (dst_q == addr_t'(NB));
        end
        assign eff_all[g] = eff;
        hc_node #(.DIMS(DIMS), .ID(g)) u_node (
            .clk    (clk),
            .rst    (rst),
            .dst_i  (dst_q),
            .busy_i (eff),
            .pass_i (pass),
            .enter_i(enter_vec[g]),
            .nogo_i (nogo_vec[g]),
            .cand_o (cand_all[g])
        );
    end

    always_comb begin
        cur_cand = cand_all[cur_q];
        hop_dim  = dim_t'(lowest_set(32'(cur_cand)));
        nbr      = cur_q ^ (addr_t'(1) << hop_dim);
        prev     = cur_q ^ (addr_t'(1) << back_dim);
    end

    always_comb begin
        step      = '0;
        enter_vec = '0;
        nogo_vec  = '0;
        claim     = 1'b0;
        rel       = 1'b0;
        load      = (state_q == ST_IDLE) && start_i;
        link_dim  = hop_dim;
        case (state_q)
            ST_PRIME: enter_vec[src_q] = 1'b1;
            ST_SEARCH: begin
                if (cur_q == dst_q) begin
                    step.win = 1'b1;
                end else if (cur_cand != '0) begin
                    step.hop       = 1'b1;
                    claim          = 1'b1;
                    enter_vec[nbr] = 1'b1;
                end else if (depth == '0) begin
                    step.lose = 1'b1;
                end else begin
                    step.back      = 1'b1;
                    rel            = 1'b1;
                    link_dim       = back_dim;
                    nogo_vec[prev] = 1'b1;
                end
            end
            default: ;
        endcase
    end

    hc_link_map #(.DIMS(DIMS), .NODES(NODES), .DW(DW)) u_map (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .init_i   (busy_init_i),
        .claim_i  (claim),
        .release_i(rel),
        .node_i   (cur_q),
        .dim_i    (link_dim),
        .map_o    (map)
    );

    hc_hop_stack #(.DIMS(DIMS), .DW(DW), .CW(CW)) u_stack (
        .clk    (clk),
        .rst    (rst),
        .clear_i(load),
        .push_i (step.hop),
        .pop_i  (step.back),
        .dim_i  (hop_dim),
        .depth_o(depth),
        .top_o  (back_dim),
        .flat_o (hops_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            iso_q   <= '0;
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    src_q   <= src_i;
                    dst_q   <= dst_i;
                    cur_q   <= src_i;
                    iso_q   <= iso_i;
                    state_q <= ST_PRIME;
                end
                ST_PRIME: state_q <= ST_SEARCH;
                ST_SEARCH: begin
                    if (step.hop)  cur_q <= nbr;
                    if (step.back) cur_q <= prev;
                    if (step.win || step.lose) begin
                        done_q  <= 1'b1;
                        ok_q    <= step.win;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o    = done_q;
    assign ok_o      = ok_q;
    assign hop_cnt_o = depth;
    assign busy_o    = map;

    int idx_a, idx_b;
    always_comb begin
        idx_a = int'(cur_q) * DIMS + int'(hop_dim);
        idx_b = int'(nbr) * DIMS + int'(hop_dim);
    end

    // R4
    hop_free_link_chk: assert property (@(posedge clk) disable iff (rst)
        step.hop |-> !eff_all[cur_q][hop_dim]);

    // R5
    claim_both_ends_chk: assert property (@(posedge clk) disable iff (rst)
        step.hop |=> (map[$past(idx_a)] && map[$past(idx_b)]));

    // R6
    iso_pass_chk: assert property (@(posedge clk) disable iff (rst)
        step.hop |-> (!iso_q[nbr] || (nbr == dst_q)));

    // R9
    hop_reduces_chk: assert property (@(posedge clk) disable iff (rst)
        step.hop |-> ($countones(nbr ^ dst_q) + 1 == $countones(cur_q ^ dst_q)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    lose_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ok_o) |-> (hop_cnt_o == '0));

endmodule

// File: tb/hc_path_engine_tb.sv
module hc_path_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  src = '0, dst = '0;
    logic [63:0] binit = '0;
    logic [15:0] iso = '0;
    logic        done, ok;
    logic [2:0]  cnt;
    logic [7:0]  hops;
    logic [63:0] busy;

    int n_run = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;

    hc_path_engine #(.DIMS(4)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .src_i(src), .dst_i(dst),
        .busy_init_i(binit), .iso_i(iso), .done_o(done), .ok_o(ok),
        .hop_cnt_o(cnt), .hops_o(hops), .busy_o(busy)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input bit c, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit lk(input logic [63:0] m, input int a, input int d);
        return m[a*4+d] | m[(a ^ (1 << d))*4+d];
    endfunction

    // arithmetic depth-first reference, lowest dimension first
    task automatic model(input int s, input int t, input logic [63:0] b0, input logic [15:0] fz,
                         output bit mok, output int mcnt, output logic [7:0] mhops, output logic [63:0] mb);
        int cand [16];
        int stk [4];
        int cur, dep, d, nb;
        mb = b0; cur = s; dep = 0; mhops = '0; mok = 0;
        for (int k = 0; k < 16; k++) cand[k] = 0;
        for (int k = 0; k < 4; k++) stk[k] = 0;
        for (int it = 0; it < 2000; it++) begin
            if (it == 0 || cand[cur] == -1) ;
            if (it == 0) begin
                cand[cur] = 0;
                for (int e = 0; e < 4; e++)
                    if (((cur ^ t) >> e & 1) && !lk(mb, cur, e) && (!fz[cur ^ (1 << e)] || (cur ^ (1 << e)) == t))
                        cand[cur] |= 1 << e;
            end
            if (cur == t) begin mok = 1; break; end
            if (cand[cur] != 0) begin
                d = 0;
                for (int e = 3; e >= 0; e--) if ((cand[cur] >> e) & 1) d = e;
                nb = cur ^ (1 << d);
                mb[cur*4+d] = 1'b1; mb[nb*4+d] = 1'b1;
                stk[dep] = d; dep++; cur = nb;
                cand[cur] = 0;
                for (int e = 0; e < 4; e++)
                    if (((cur ^ t) >> e & 1) && !lk(mb, cur, e) && (!fz[cur ^ (1 << e)] || (cur ^ (1 << e)) == t))
                        cand[cur] |= 1 << e;
            end else if (dep == 0) begin
                break;
            end else begin
                dep--; d = stk[dep]; nb = cur ^ (1 << d);
                mb[cur*4+d] = 1'b0; mb[nb*4+d] = 1'b0;
                cur = nb;
                cand[cur] &= ~(1 << d);
            end
        end
        mcnt = dep;
        for (int k = 0; k < 4; k++) if (k < dep) mhops[k*2 +: 2] = 2'(stk[k]);
    endtask

    task automatic run(input logic [3:0] s, input logic [3:0] t, input logic [63:0] b,
                       input logic [15:0] fz, input int poke, output int lat);
        @(negedge clk);
        src = s; dst = t; binit = b; iso = fz; start = 1'b1;
        @(negedge clk);
        start = 1'b0; lat = 1;
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
            if (poke != 0 && lat == 3) begin
                src = 4'(s + 1); dst = 4'(t ^ 1); binit = '0; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
    endtask

    task automatic compare(input string req, input int s, input int t, input logic [63:0] b, input logic [15:0] fz);
        bit mok; int mcnt; logic [7:0] mh; logic [63:0] mb; logic [7:0] mask;
        model(s, t, b, fz, mok, mcnt, mh, mb);
        mask = '0;
        for (int k = 0; k < 4; k++) if (k < mcnt) mask[k*2 +: 2] = 2'b11;
        check(done === 1'b1, req, 64'(done), 64'd1);
        check(ok === mok, req, 64'(ok), 64'(mok));
        check(int'(cnt) == mcnt, req, 64'(cnt), 64'(mcnt));
        check((hops & mask) == mh, req, 64'(hops & mask), 64'(mh));
        check(busy == mb, req, busy, mb);
    endtask

    initial begin
        int lat, h;
        logic [31:0] lf;
        logic [7:0] eh, m8;
        logic [63:0] eb;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(done == 0 && ok == 0 && cnt == 0, "R1", {done, ok, cnt}, 0);
        check(busy == 0, "R1", busy, 0);
        rst = 1'b0;

        // R3 / R2 clean sweep of all pairs
        for (int s = 0; s < 16; s++) begin
            for (int t = 0; t < 16; t++) begin
                run(4'(s), 4'(t), '0, '0, 0, lat);
                h = $countones(4'(s ^ t));
                eh = '0; eb = '0;
                begin
                    int k, c;
                    c = s; k = 0;
                    for (int e = 0; e < 4; e++) if (((s ^ t) >> e) & 1) begin
                        eh[k*2 +: 2] = 2'(e); k++;
                        eb[c*4+e] = 1'b1; eb[(c ^ (1 << e))*4+e] = 1'b1; c = c ^ (1 << e);
                    end
                end
                m8 = '0;
                for (int k = 0; k < 4; k++) if (k < h) m8[k*2 +: 2] = 2'b11;
                if (s == t) begin
                    check(lat == 3 && ok && cnt == 0, "R2", 64'(lat), 64'd3);
                end else begin
                    check(lat == h + 3, "R3 latency", 64'(lat), 64'(h + 3));
                    check(ok == 1 && int'(cnt) == h, "R3 count", 64'(cnt), 64'(h));
                    check((hops & m8) == eh, "R3 order", 64'(hops & m8), 64'(eh));
                    check(busy == eb, "R5 clean map", busy, eb);
                end
            end
        end

        // R6 fenced middle node forces detour 0->2->3
        run(4'd0, 4'd3, '0, 16'h0002, 0, lat);
        check(ok && cnt == 2 && hops[3:0] == 4'b0001, "R6 detour", 64'(hops[3:0]), 64'b0001);
        // R6 fenced destination still reachable
        run(4'd0, 4'd1, '0, 16'h0002, 0, lat);
        check(ok && cnt == 1 && hops[1:0] == 2'd0, "R6 fenced dest", 64'(cnt), 64'd1);

        // R7 backtrack: links 3-7 (dim2) and 5-7 (dim1) busy, route 0->2->6->7
        eb = '0; eb[3*4+2] = 1'b1; eb[5*4+1] = 1'b1;
        run(4'd0, 4'd7, eb, '0, 0, lat);
        check(ok && cnt == 3 && hops[5:0] == {2'd0, 2'd2, 2'd1}, "R7 backtrack", 64'(hops[5:0]), 64'b001001);
        check(busy == (eb | 64'h0 | (64'd1 << 2*4+1) | (64'd1 << 0*4+1) | (64'd1 << 6*4+2) | (64'd1 << 2*4+2)
                        | (64'd1 << 7*4+0) | (64'd1 << 6*4+0)), "R5 backtrack map", busy, 0);
        // R4 busy link noted only at far end is still avoided
        eb = '0; eb[1*4+0] = 1'b1;
        run(4'd0, 4'd1, eb, '0, 0, lat);
        check(!ok, "R4 far-end busy", 64'(ok), 64'd0);

        // R8 blocked source
        eb = 64'h000F;
        run(4'd0, 4'd15, eb, '0, 0, lat);
        check(!ok && cnt == 0 && busy == eb, "R8 fail", busy, eb);

        // R11 pulse and hold
        run(4'd1, 4'd14, '0, '0, 0, lat);
        eb = busy;
        @(negedge clk);
        check(!done && ok && cnt == 4 && busy == eb, "R11 hold", {done, ok}, 2'b01);

        // R10 start during search ignored
        eb = '0; eb[3*4+2] = 1'b1; eb[5*4+1] = 1'b1;
        run(4'd0, 4'd7, eb, '0, 1, lat);
        compare("R10", 0, 7, eb, '0);

        // R7 R4 R6 pseudo-random patterns against depth-first model
        lf = 32'hACE1_2345;
        for (int p = 0; p < 300; p++) begin
            logic [63:0] b; logic [15:0] fz; int s, t;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            b[31:0] = lf; lf = lf * 32'd1664525 + 32'd1013904223;
            b[63:32] = lf; lf = lf * 32'd1664525 + 32'd1013904223;
            b = b & {lf, lf ^ 32'h5A5A_A5A5};
            lf = lf * 32'd1664525 + 32'd1013904223;
            fz = lf[15:0] & lf[31:16];
            s = int'(lf[3:0]); t = int'(lf[7:4]);
            run(4'(s), 4'(t), b, fz, 0, lat);
            compare("R7 pattern", s, t, b, fz);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule